// File: doc/BRIEF.md
# Replayable Dual-Clock FIFO

This block is a first-in first-out buffer with separate write and read clocks. Besides normal streaming, it can replay its contents. A replay request on the read side moves the read position back to the first word written since the last reset. Every word stored after that point can then be read a second time, in the same order. The buffer keeps those words because writers keep the total number of words written since reset within a fixed limit.

The read side runs in one of two modes, chosen by a static pin.
- **Standard mode:** a read enable fetches the next word into a registered output, which is valid one cycle later.
- **Fall-through mode:** the head word sits on the output before it is requested, and a read enable consumes it. The output register adds one slot of capacity.

In both modes a single read flag tells the consumer that a read may be issued. The flag is forced low for a fixed number of read-clock cycles while a replay is being set up. The write and read pointers cross between the clock domains as Gray codes through two-flop synchronizers.

Top module: `rtx_fifo`

## Requirements
- R1: While `rst_n` is low, `rd_flag` is 0, `wr_ok` is 1, `rt_err` is 0 and `rd_data` is 0.
- R2: In standard mode (`fwft_mode`=0), `rd_flag` is 1 when a stored word is available. A read cycle is a rising `rclk` edge with `rd_en`=1 and `rd_flag`=1. It places the oldest unread word on `rd_data` from the next cycle, and words come out in write order.
- R3: In fall-through mode (`fwft_mode`=1), the oldest unread word is shown on `rd_data` while `rd_flag` is 1, with no read enable. A read cycle consumes that word, and `rd_data` and `rd_flag` do not change without one.
- R4: A rising `rclk` edge with `rt_req`=1 and `rt_arm`=1 starts a replay. From the next cycle, `rd_flag` is 0 for at least SETUP_CYC cycles: exactly SETUP_CYC cycles in standard mode, and one more in fall-through mode while the output register reloads. `rd_en` has no effect during that time.
- R5: When replay setup ends, reading resumes with the first word written after the most recent reset, followed by the later words in write order.
- R6: `rt_req` with `rt_arm`=0 has no effect: `rd_flag` stays as it was and the read position is kept.
- R7: Once more than depth−2 words have been written since reset, a replay request is refused. `rt_err` is 1 for exactly the one cycle after the request, `rd_flag` does not drop, and the next word read is the one that was due before the request.
- R8: `wr_ok` goes low once the buffer holds depth unread words in standard mode, or depth+1 in fall-through mode. A write presented while `wr_ok` is 0 is discarded.
- R9: After every stored word has been read, `rd_flag` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_mode | input | 1 | 1 = fall-through reads, 0 = standard reads; held static |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| wr_ok | output | 1 | Room for a write |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Output register |
| rd_flag | output | 1 | A read may be issued (not-empty or output-ready) |
| rt_arm | input | 1 | Enables replay requests |
| rt_req | input | 1 | Replay request strobe, sampled on `rclk` |
| rt_err | output | 1 | One-cycle pulse for a refused replay request |

## Verification
The bench builds the block with 8-bit words, a three-bit address (depth 8) and a three-cycle setup count, and runs the same sequence once in each read mode.

That small depth brings the refusal boundary within reach. A sweep of depth−2 words leaves replay allowed, and a single extra word makes the next request fail.

The depth also lets the bench fill the buffer completely. This shows the capacity difference between the modes and carries both pointers past their wrap point. The exact flag-low window is counted cycle by cycle against the setup parameter.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;
  // binary to reflected Gray code
  function automatic int unsigned bin2gray(int unsigned b);
    return b ^ (b >> 1);
  endfunction

  // Gray code back to binary (prefix xor)
  function automatic int unsigned gray2bin(int unsigned g);
    int unsigned b;
    b = g;
    for (int s = 1; s < 32; s = s << 1) b = b ^ (b >> s);
    return b;
  endfunction

  // true when a write count exceeds the replay-safe limit
  function automatic logic over_limit(int unsigned count, int unsigned depth);
    return count > depth - 2;
  endfunction
endpackage

// File: rtl/rtx_sync.sv
module rtx_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rtx_mem.sv
module rtx_mem #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rtx_wr_ctl.sv
module rtx_wr_ctl
  import rtx_fifo_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  output logic          wr_ok,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          lim
);
  localparam int PW = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [PW-1:0] wptr;
  logic [PW-1:0] wptr_nxt;
  logic [PW-1:0] full_pat;
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] occ;

  assign wptr_nxt = wptr + 1'b1;
  assign full_pat = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};
  assign wr_ok    = (wgray != full_pat);
  assign wr_fire  = wr_en && wr_ok;
  assign waddr    = wptr[AW-1:0];
  assign rbin_s   = PW'(gray2bin(32'(rgray_s)));
  assign occ      = wptr - rbin_s;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
      lim   <= 1'b0;
    end else if (wr_fire) begin
      wptr  <= wptr_nxt;
      wgray <= PW'(bin2gray(32'(wptr_nxt)));
      if (over_limit(32'(wptr) + 32'd1, DEPTH)) lim <= 1'b1;
    end
  end

  // R7
  lim_sticky_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    lim |=> lim);

  // R8
  occupancy_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    occ <= PW'(DEPTH));
endmodule

// File: rtl/rtx_rd_ctl.sv
module rtx_rd_ctl
  import rtx_fifo_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 3,
  parameter int SETUP_CYC = 3
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft_mode,
  input  logic          rd_en,
  input  logic          rt_arm,
  input  logic          rt_req,
  input  logic [AW:0]   wgray_s,
  input  logic          lim_s,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag,
  output logic          rt_err
);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(SETUP_CYC + 1);
  localparam logic [CW-1:0] SETUP_INIT = CW'(SETUP_CYC);

  logic [PW-1:0] rptr;
  logic [PW-1:0] rptr_nxt;
  logic [CW-1:0] setup_cnt;
  logic          ov;
  logic          ram_empty;
  logic          setup_busy;
  logic          rt_seen;
  logic          rt_go;
  logic          rt_err_evt;
  logic          pop;

  assign rptr_nxt   = rptr + 1'b1;
  assign raddr      = rptr[AW-1:0];
  assign ram_empty  = (rgray == wgray_s);
  assign setup_busy = (setup_cnt != '0);
  assign rt_seen    = rt_req && rt_arm && !setup_busy;
  assign rt_go      = rt_seen && !lim_s;
  assign rt_err_evt = rt_seen && lim_s;
  assign rd_flag    = fwft_mode ? ov : (!ram_empty && !setup_busy);
  assign pop = !rt_go && (fwft_mode ? (!ram_empty && !setup_busy && (!ov || rd_en))
                                    : (rd_en && rd_flag));

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr      <= '0;
      rgray     <= '0;
      setup_cnt <= '0;
      ov        <= 1'b0;
      rd_data   <= '0;
      rt_err    <= 1'b0;
    end else begin
      rt_err <= rt_err_evt;
      if (rt_go) begin
        rptr      <= '0;
        rgray     <= '0;
        ov        <= 1'b0;
        setup_cnt <= SETUP_INIT;
      end else begin
        if (setup_busy) setup_cnt <= setup_cnt - 1'b1;
        if (pop) begin
          rptr    <= rptr_nxt;
          rgray   <= PW'(bin2gray(32'(rptr_nxt)));
          rd_data <= mem_q;
          if (fwft_mode) ov <= 1'b1;
        end else if (fwft_mode && rd_en && ov) begin
          ov <= 1'b0;
        end
      end
    end
  end

  // R4
  rt_accept_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rt_go |=> (!rd_flag && setup_cnt == SETUP_INIT));

  // R4
  setup_quiet_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    setup_busy |-> !rd_flag);

  // R5
  rewind_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rt_go |=> (rptr == '0));

  // R6
  no_arm_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (rt_req && !rt_arm && !setup_busy) |=> !setup_busy);

  // R7
  err_ignored_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rt_err_evt |=> (rt_err && !setup_busy));

  // R3
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft_mode && ov && !rd_en && !rt_go) |=> (ov && $stable(rd_data)));
endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int SETUP_CYC = 3
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fwft_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ok,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_flag,
  input  logic              rt_arm,
  input  logic              rt_req,
  output logic              rt_err
);
  localparam int PW = ADDR_W + 1;

  logic              wr_fire;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [PW-1:0]     wgray;
  logic [PW-1:0]     rgray;
  logic [PW-1:0]     wgray_s;
  logic [PW-1:0]     rgray_s;
  logic              lim;
  logic              lim_s;
  logic [DATA_W-1:0] mem_q;

  rtx_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_q)
  );

  rtx_wr_ctl #(.AW(ADDR_W)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .wr_ok(wr_ok), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray), .lim(lim)
  );

  rtx_sync #(.W(PW)) u_sync_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  rtx_sync #(.W(PW)) u_sync_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));
  rtx_sync #(.W(1))  u_sync_lim (.clk(rclk), .rst_n(rst_n), .d(lim),   .q(lim_s));

  rtx_rd_ctl #(.DW(DATA_W), .AW(ADDR_W), .SETUP_CYC(SETUP_CYC)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .fwft_mode(fwft_mode), .rd_en(rd_en),
    .rt_arm(rt_arm), .rt_req(rt_req), .wgray_s(wgray_s), .lim_s(lim_s),
    .mem_q(mem_q), .raddr(raddr), .rgray(rgray), .rd_data(rd_data),
    .rd_flag(rd_flag), .rt_err(rt_err)
  );
endmodule

// File: tb/rtx_fifo_tb.sv
module rtx_fifo_tb;
  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int SETUP = 3;
  localparam int DEPTH = 1 << AW;

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fwft_mode = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ok;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_flag;
  logic          rt_arm = 1'b0;
  logic          rt_req = 1'b0;
  logic          rt_err;

  int checks = 0;
  int fails  = 0;

  rtx_fifo #(.DATA_W(DW), .ADDR_W(AW), .SETUP_CYC(SETUP)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .wr_en(wr_en), .wr_data(wr_data), .wr_ok(wr_ok), .rd_en(rd_en),
    .rd_data(rd_data), .rd_flag(rd_flag), .rt_arm(rt_arm), .rt_req(rt_req),
    .rt_err(rt_err)
  );

  always #2.5 wclk = ~wclk;
  initial begin
    #1.3;
    forever #2.5 rclk = ~rclk;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] val(input int k, input int m);
    return DW'(k * 29 + 5 + m * 3);
  endfunction

  task automatic wr_one(input logic [DW-1:0] v);
    @(negedge wclk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic rd_one(input logic [DW-1:0] exp, input string req);
    @(negedge rclk);
    chk({req, " flag"}, int'(rd_flag), 1);
    if (fwft_mode) chk({req, " shown word"}, int'(rd_data), int'(exp));
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
    if (!fwft_mode) chk({req, " read word"}, int'(rd_data), int'(exp));
  endtask

  task automatic run_mode(input int m);
    int lows;
    int taken;
    fwft_mode = m[0];
    rst_n = 1'b0;
    rt_arm = 1'b0;
    repeat (4) @(negedge rclk);
    // R1 reset state
    chk("R1 rd_flag", int'(rd_flag), 0);
    chk("R1 wr_ok", int'(wr_ok), 1);
    chk("R1 rt_err", int'(rt_err), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge wclk);

    // depth-2 words: still replayable
    for (int k = 0; k < DEPTH - 2; k++) wr_one(val(k, m));
    repeat (10) @(negedge rclk);
    for (int k = 0; k < DEPTH - 2; k++) rd_one(val(k, m), m ? "R3" : "R2");
    repeat (3) @(negedge rclk);
    chk("R9 drained", int'(rd_flag), 0);

    // R4 replay setup
    @(negedge rclk);
    rt_arm = 1'b1;
    rt_req = 1'b1;
    @(negedge rclk);
    rt_req = 1'b0;
    chk("R4 flag low after request", int'(rd_flag), 0);
    chk("R4 no error", int'(rt_err), 0);
    rd_en = 1'b1;
    lows = 1;
    @(negedge rclk);
    if (!rd_flag) lows++;
    rd_en = 1'b0;
    while (!rd_flag && lows < 20) begin
      @(negedge rclk);
      if (!rd_flag) lows++;
    end
    chk("R4 setup low cycles", lows, SETUP + m);

    // R5 replay from first word, R6 unarmed request ignored
    for (int k = 0; k < 2; k++) rd_one(val(k, m), "R5");
    @(negedge rclk);
    rt_arm = 1'b0;
    rt_req = 1'b1;
    @(negedge rclk);
    rt_req = 1'b0;
    chk("R6 rt_err", int'(rt_err), 0);
    chk("R6 flag kept", int'(rd_flag), 1);
    for (int k = 2; k < DEPTH - 2; k++) rd_one(val(k, m), "R6 R5");
    repeat (3) @(negedge rclk);
    chk("R9 drained after replay", int'(rd_flag), 0);

    // R7 limit exceeded by one word
    wr_one(val(DEPTH - 2, m));
    repeat (10) @(negedge rclk);
    rt_arm = 1'b1;
    rt_req = 1'b1;
    @(negedge rclk);
    rt_req = 1'b0;
    chk("R7 rt_err pulse", int'(rt_err), 1);
    chk("R7 flag kept", int'(rd_flag), 1);
    @(negedge rclk);
    chk("R7 rt_err one cycle", int'(rt_err), 0);
    rd_one(val(DEPTH - 2, m), "R7 position kept");
    repeat (3) @(negedge rclk);
    chk("R9 drained after refusal", int'(rd_flag), 0);

    // R8 capacity
    taken = 0;
    for (int i = 0; i < DEPTH + 4; i++) begin
      @(negedge wclk);
      if (!wr_ok) break;
      wr_one(val(DEPTH - 1 + i, m));
      taken++;
      repeat (8) @(negedge wclk);
    end
    chk("R8 capacity", taken, DEPTH + m);
    chk("R8 wr_ok low", int'(wr_ok), 0);
    wr_one(8'hEE);
    repeat (8) @(negedge rclk);
    for (int k = 0; k < taken; k++) rd_one(val(DEPTH - 1 + k, m), "R8");
    repeat (10) @(negedge rclk);
    chk("R8 extra write discarded", int'(rd_flag), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    run_mode(0);
    run_mode(1);
    finish_run();
  end
endmodule